// File: doc/BRIEF.md
# Time Base, Watchdog and Tone Generator

This block turns a 32768 Hz clock enable into three timing services for a display controller. The first is a time-base square wave at a rate of 1 Hz to 128 Hz, chosen by a 3-bit code. The second is a watchdog that times out after four periods of that square wave. The third is a differential buzzer pair at 2048 Hz or 4096 Hz. The time base and the watchdog share a single counter chain. Its low 8 bits form the divide-by-256 prescaler, which produces 128 Hz. Its upper 7 bits divide further down to 1 Hz.

A command decoder outside this block sends one-cycle pulses into it. The pulses enable, disable or clear the timer and the watchdog, enable or disable the interrupt, load the rate code, and select or silence the tone. The interrupt output is active low. It is driven by a latched watchdog timeout, or, when the timer is enabled, by the time-base square wave. A timeout takes priority over the square wave. The timeout stays latched until the watchdog is cleared or the interrupt is disabled.

Top module: `timebase_wdt_tone`

## Requirements
- R1: After reset, the timer, the watchdog and the interrupt are all disabled, the tone is off and the rate code is 0. The outputs are then tb_wave=0, wdt_flag=0, irq_n=1, tone_p=0 and tone_n=0.
- R2: A 15-bit chain counts `tick`. The selected bit is chain bit 14-sel, which gives 2^sel Hz at a 32768 Hz tick rate (256 ticks per period for sel=7, 512 ticks for sel=6). While the timer is enabled, tb_wave shows the selected bit one cycle after the bit changes.
- R3: While the timer is disabled, tb_wave is 0 and the chain keeps counting.
- R4: A timer-clear pulse sets the whole chain to zero and overrides a tick in the same cycle. Two cycles after the pulse, tb_wave is 0.
- R5: While the watchdog is enabled, a 2-bit stage counts the completed periods of the selected bit. A completed period is a tick that carries out of chain bits [14-sel:0]. The fourth completed period sets wdt_flag. The flag never rises while the watchdog is disabled.
- R6: wdt_flag stays set until a watchdog-clear pulse or an interrupt-disable pulse arrives. Either pulse clears the flag in the next cycle. Either pulse wins over a timeout in the same cycle. Watchdog-clear also zeroes the 2-bit stage and leaves the chain untouched.
- R7: irq_n is 0 when the interrupt is enabled and either wdt_flag is set, or the timer is enabled and the selected bit is 1. A set wdt_flag forces irq_n low whatever the wave does. Otherwise irq_n is 1, and it is 1 two cycles after an interrupt-disable pulse.
- R8: The timer, watchdog and interrupt enables are independent of each other. Each takes effect in the cycle after its pulse. If an enable pulse and a disable pulse for the same function arrive together, the disable wins.
- R9: A free 4-bit tone counter counts `tick`. The high tone follows bit 2 of this counter (8 ticks per period) and the low tone follows bit 3 (16 ticks per period). While a tone is on, tone_n is the complement of tone_p. When the tone is off, both outputs are 0. If several tone pulses arrive together, off beats high, and high beats low.
- R10: A rate-write pulse loads the 3-bit rate code, and the code takes effect from the next cycle. The code selects both the time-base rate and the watchdog timeout, which is four periods of the time base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 32768 Hz clock enable |
| tmr_en_cmd | input | 1 | Timer enable pulse |
| tmr_dis_cmd | input | 1 | Timer disable pulse |
| tmr_clr_cmd | input | 1 | Clear prescaler and time-base chain |
| wdt_en_cmd | input | 1 | Watchdog enable pulse |
| wdt_dis_cmd | input | 1 | Watchdog disable pulse |
| wdt_clr_cmd | input | 1 | Clear watchdog stage and flag |
| irq_en_cmd | input | 1 | Interrupt enable pulse |
| irq_dis_cmd | input | 1 | Interrupt disable pulse (also clears flag) |
| rate_we | input | 1 | Load rate code |
| rate_sel | input | 3 | Rate code, 0 = 1 Hz up to 7 = 128 Hz |
| tone_hi_cmd | input | 1 | Select 4096 Hz tone |
| tone_lo_cmd | input | 1 | Select 2048 Hz tone |
| tone_off_cmd | input | 1 | Silence tone |
| tb_wave | output | 1 | Time-base square wave |
| wdt_flag | output | 1 | Latched watchdog timeout |
| irq_n | output | 1 | Active-low interrupt |
| tone_p | output | 1 | Tone, true phase |
| tone_n | output | 1 | Tone, inverted phase |

## Verification
A watchdog timeout and a watchdog-clear pulse can fall on the same clock edge. The bench's reference model knows from its own state when the next tick will complete the fourth period, and the bench drives the clear pulse on exactly that cycle. The flag must stay low, and the model, which gives the clear pulse priority, is compared with the outputs on every cycle. The same approach covers an enable pulse and a disable pulse arriving together, a timer clear arriving on a tick, and the interaction of interrupt-disable with a flag that is already set.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  typedef enum logic [1:0] {
    TONE_OFF  = 2'd0,
    TONE_LOW  = 2'd1,
    TONE_HIGH = 2'd2
  } tone_mode_e;

  localparam int N_FUNC = 3;
  localparam int F_TMR  = 0;
  localparam int F_WDT  = 1;
  localparam int F_IRQ  = 2;
endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
  import tbw_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_FUNC-1:0]  set_cmd,
  input  logic [N_FUNC-1:0]  clr_cmd,
  input  logic               rate_we,
  input  logic [SEL_W-1:0]   rate_sel,
  input  logic               tone_hi_cmd,
  input  logic               tone_lo_cmd,
  input  logic               tone_off_cmd,
  output logic [N_FUNC-1:0]  en_q,
  output logic [SEL_W-1:0]   sel_q,
  output tone_mode_e         mode_q
);
  // One set/clear flop per function; disable has priority.
  for (genvar f = 0; f < N_FUNC; f++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst)             en_q[f] <= 1'b0;
      else if (clr_cmd[f]) en_q[f] <= 1'b0;
      else if (set_cmd[f]) en_q[f] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          sel_q <= '0;
    else if (rate_we) sel_q <= rate_sel;
  end

  always_ff @(posedge clk) begin
    if (rst)               mode_q <= TONE_OFF;
    else if (tone_off_cmd) mode_q <= TONE_OFF;
    else if (tone_hi_cmd)  mode_q <= TONE_HIGH;
    else if (tone_lo_cmd)  mode_q <= TONE_LOW;
  end
endmodule

// File: rtl/tbw_chain.sv
module tbw_chain #(
  parameter int PRE_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             sel_bit,
  output logic             period_evt
);
  localparam int CODES   = 1 << SEL_W;
  localparam int TB_W    = CODES - 1;
  localparam int CHAIN_W = PRE_W + TB_W;
  localparam logic [PRE_W-1:0] PRE_ONE = 1;
  localparam logic [TB_W-1:0]  TB_ONE  = 1;

  logic [PRE_W-1:0]   pre_q;
  logic [TB_W-1:0]    tb_q;
  logic               pre_carry;
  logic [CHAIN_W-1:0] chain;
  logic [CODES-1:0]   code_bit;
  logic [CODES-1:0]   code_wrap;

  assign pre_carry = tick & (&pre_q);
  assign chain     = {tb_q, pre_q};

  // Shared prescaler: 32768 Hz down to 128 Hz.
  always_ff @(posedge clk) begin
    if (rst || clr)  pre_q <= '0;
    else if (tick)   pre_q <= pre_q + PRE_ONE;
  end

  // Time-base stage: 128 Hz down to 1 Hz.
  always_ff @(posedge clk) begin
    if (rst || clr)     tb_q <= '0;
    else if (pre_carry) tb_q <= tb_q + TB_ONE;
  end

  // Per rate code: the square-wave bit and the full-period wrap.
  for (genvar k = 0; k < CODES; k++) begin : g_code
    localparam int IDX = CHAIN_W - 1 - k;
    assign code_bit[k]  = chain[IDX];
    assign code_wrap[k] = &chain[IDX:0];
  end

  assign sel_bit    = code_bit[sel];
  assign period_evt = tick & ~clr & code_wrap[sel];
endmodule

// File: rtl/tbw_wdog.sv
module tbw_wdog #(
  parameter int WDT_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic period_evt,
  input  logic clr_stage,
  input  logic clr_flag,
  output logic flag
);
  localparam logic [WDT_W-1:0] STG_ONE = 1;

  logic [WDT_W-1:0] stage_q;
  logic             count_now;
  logic             timeout;

  assign count_now = enable & period_evt;
  assign timeout   = count_now & (&stage_q);

  always_ff @(posedge clk) begin
    if (rst || clr_stage) stage_q <= '0;
    else if (count_now)   stage_q <= stage_q + STG_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_flag) flag <= 1'b0;
    else if (timeout)    flag <= 1'b1;
  end
endmodule

// File: rtl/tbw_tone.sv
module tbw_tone
  import tbw_pkg::*;
#(
  parameter int TONE_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  tone_mode_e mode,
  output logic       tone_p,
  output logic       tone_n
);
  localparam int HI_BIT = TONE_W - 2;
  localparam int LO_BIT = TONE_W - 1;
  localparam logic [TONE_W-1:0] CNT_ONE = 1;

  logic [TONE_W-1:0] cnt_q;
  logic              sq;
  logic              on;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + CNT_ONE;
  end

  always_comb begin
    case (mode)
      TONE_HIGH: begin sq = cnt_q[HI_BIT]; on = 1'b1; end
      TONE_LOW:  begin sq = cnt_q[LO_BIT]; on = 1'b1; end
      default:   begin sq = 1'b0;          on = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tone_p <= 1'b0;
      tone_n <= 1'b0;
    end else begin
      tone_p <= on & sq;
      tone_n <= on & ~sq;
    end
  end
endmodule

// File: rtl/timebase_wdt_tone.sv
module timebase_wdt_tone
  import tbw_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int SEL_W  = 3,
  parameter int WDT_W  = 2,
  parameter int TONE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             tmr_en_cmd,
  input  logic             tmr_dis_cmd,
  input  logic             tmr_clr_cmd,
  input  logic             wdt_en_cmd,
  input  logic             wdt_dis_cmd,
  input  logic             wdt_clr_cmd,
  input  logic             irq_en_cmd,
  input  logic             irq_dis_cmd,
  input  logic             rate_we,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             tone_hi_cmd,
  input  logic             tone_lo_cmd,
  input  logic             tone_off_cmd,
  output logic             tb_wave,
  output logic             wdt_flag,
  output logic             irq_n,
  output logic             tone_p,
  output logic             tone_n
);
  logic [N_FUNC-1:0] set_cmd, clr_cmd, en_q;
  logic [SEL_W-1:0]  sel_q;
  tone_mode_e        tone_mode;
  logic              tmr_en_w, wdt_en_w, irq_en_w;
  logic              sel_bit, period_evt;

  assign set_cmd[F_TMR] = tmr_en_cmd;
  assign set_cmd[F_WDT] = wdt_en_cmd;
  assign set_cmd[F_IRQ] = irq_en_cmd;
  assign clr_cmd[F_TMR] = tmr_dis_cmd;
  assign clr_cmd[F_WDT] = wdt_dis_cmd;
  assign clr_cmd[F_IRQ] = irq_dis_cmd;

  assign tmr_en_w = en_q[F_TMR];
  assign wdt_en_w = en_q[F_WDT];
  assign irq_en_w = en_q[F_IRQ];

  tbw_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .set_cmd      (set_cmd),
    .clr_cmd      (clr_cmd),
    .rate_we      (rate_we),
    .rate_sel     (rate_sel),
    .tone_hi_cmd  (tone_hi_cmd),
    .tone_lo_cmd  (tone_lo_cmd),
    .tone_off_cmd (tone_off_cmd),
    .en_q         (en_q),
    .sel_q        (sel_q),
    .mode_q       (tone_mode)
  );

  tbw_chain #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .clr        (tmr_clr_cmd),
    .sel        (sel_q),
    .sel_bit    (sel_bit),
    .period_evt (period_evt)
  );

  tbw_wdog #(.WDT_W(WDT_W)) u_wdog (
    .clk        (clk),
    .rst        (rst),
    .enable     (wdt_en_w),
    .period_evt (period_evt),
    .clr_stage  (wdt_clr_cmd),
    .clr_flag   (wdt_clr_cmd | irq_dis_cmd),
    .flag       (wdt_flag)
  );

  tbw_tone #(.TONE_W(TONE_W)) u_tone (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .mode   (tone_mode),
    .tone_p (tone_p),
    .tone_n (tone_n)
  );

  // Registered outputs; a latched timeout overrides the wave.
  always_ff @(posedge clk) begin
    if (rst) begin
      tb_wave <= 1'b0;
      irq_n   <= 1'b1;
    end else begin
      tb_wave <= tmr_en_w & sel_bit;
      irq_n   <= ~(irq_en_w & (wdt_flag | (tmr_en_w & sel_bit)));
    end
  end
endmodule

// File: rtl/tbw_checker.sv
module tbw_checker (
  input logic       clk,
  input logic       rst,
  input logic       tmr_dis_cmd,
  input logic       tmr_clr_cmd,
  input logic       wdt_clr_cmd,
  input logic       irq_dis_cmd,
  input logic       tone_off_cmd,
  input logic       tb_wave,
  input logic       wdt_flag,
  input logic       irq_n,
  input logic       tone_p,
  input logic       tone_n,
  input logic       irq_en,
  input logic       wdt_en,
  input logic [1:0] tone_mode
);
  p_tone_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(tone_p && tone_n));

  p_tone_pair_r9: assert property (@(posedge clk) disable iff (rst)
    (tone_mode != 2'd0) |=> (tone_p != tone_n));

  p_tone_off_r9: assert property (@(posedge clk) disable iff (rst)
    tone_off_cmd |=> ##1 (!tone_p && !tone_n));

  p_wave_dis_r3: assert property (@(posedge clk) disable iff (rst)
    tmr_dis_cmd |=> ##1 !tb_wave);

  p_clr_zero_r4: assert property (@(posedge clk) disable iff (rst)
    tmr_clr_cmd |=> ##1 !tb_wave);

  p_flag_needs_wdt_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_flag) |-> $past(wdt_en));

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (wdt_flag && !wdt_clr_cmd && !irq_dis_cmd) |=> wdt_flag);

  p_flag_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (wdt_clr_cmd || irq_dis_cmd) |=> !wdt_flag);

  p_wdt_prio_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_en && wdt_flag) |=> !irq_n);

  p_irq_off_r7: assert property (@(posedge clk) disable iff (rst)
    irq_dis_cmd |=> ##1 irq_n);
endmodule

bind timebase_wdt_tone tbw_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .tmr_dis_cmd  (tmr_dis_cmd),
  .tmr_clr_cmd  (tmr_clr_cmd),
  .wdt_clr_cmd  (wdt_clr_cmd),
  .irq_dis_cmd  (irq_dis_cmd),
  .tone_off_cmd (tone_off_cmd),
  .tb_wave      (tb_wave),
  .wdt_flag     (wdt_flag),
  .irq_n        (irq_n),
  .tone_p       (tone_p),
  .tone_n       (tone_n),
  .irq_en       (irq_en_w),
  .wdt_en       (wdt_en_w),
  .tone_mode    (tone_mode)
);

// File: tb/sim_timebase_wdt_tone.sv
`timescale 1ns/1ps
module sim_timebase_wdt_tone;
  localparam int C_TEN = 0, C_TDIS = 1, C_TCLR = 2, C_WEN = 3, C_WDIS = 4,
                 C_WCLR = 5, C_IEN = 6, C_IDIS = 7, C_RWE = 8, C_THI = 9,
                 C_TLO = 10, C_TOFF = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [11:0] cmdv = '0;
  logic [2:0]  rsel = '0;
  int          tick_mode = 0;
  int          tick_ctr = 0;
  logic        tb_wave, wdt_flag, irq_n, tone_p, tone_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  timebase_wdt_tone u0 (
    .clk(clk), .rst(rst), .tick(tick),
    .tmr_en_cmd(cmdv[C_TEN]), .tmr_dis_cmd(cmdv[C_TDIS]), .tmr_clr_cmd(cmdv[C_TCLR]),
    .wdt_en_cmd(cmdv[C_WEN]), .wdt_dis_cmd(cmdv[C_WDIS]), .wdt_clr_cmd(cmdv[C_WCLR]),
    .irq_en_cmd(cmdv[C_IEN]), .irq_dis_cmd(cmdv[C_IDIS]),
    .rate_we(cmdv[C_RWE]), .rate_sel(rsel),
    .tone_hi_cmd(cmdv[C_THI]), .tone_lo_cmd(cmdv[C_TLO]), .tone_off_cmd(cmdv[C_TOFF]),
    .tb_wave(tb_wave), .wdt_flag(wdt_flag), .irq_n(irq_n),
    .tone_p(tone_p), .tone_n(tone_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Tick pattern: mode 0 every cycle, mode 1 every third cycle.
  always @(negedge clk) begin
    tick_ctr <= tick_ctr + 1;
    tick <= (tick_mode == 0) ? 1'b1 : ((tick_ctr % 3) == 0);
  end

  // Behavioural reference model.
  int m_cnt, m_tcnt, m_wcnt, m_sel, m_tmode;
  bit m_ten, m_wen, m_ien, m_flag;
  bit m_tb, m_irqn, m_tp, m_tn;

  always @(posedge clk) begin
    int idx, period;
    bit bitv, evt, sq;
    if (rst) begin
      m_cnt = 0; m_tcnt = 0; m_wcnt = 0; m_sel = 0; m_tmode = 0;
      m_ten = 0; m_wen = 0; m_ien = 0; m_flag = 0;
      m_tb = 0; m_irqn = 1; m_tp = 0; m_tn = 0;
    end else begin
      idx    = 14 - m_sel;
      period = 1 << (idx + 1);
      bitv   = ((m_cnt >> idx) & 1) != 0;
      m_tb   = m_ten && bitv;
      m_irqn = !(m_ien && (m_flag || (m_ten && bitv)));
      sq     = (m_tmode == 2) ? (((m_tcnt >> 2) & 1) != 0) : (((m_tcnt >> 3) & 1) != 0);
      m_tp   = (m_tmode != 0) && sq;
      m_tn   = (m_tmode != 0) && !sq;
      evt    = tick && !cmdv[C_TCLR] && (((m_cnt + 1) % period) == 0);
      if (cmdv[C_WCLR] || cmdv[C_IDIS]) m_flag = 0;
      else if (m_wen && evt && m_wcnt == 3) m_flag = 1;
      if (cmdv[C_WCLR]) m_wcnt = 0;
      else if (m_wen && evt) m_wcnt = (m_wcnt + 1) % 4;
      if (cmdv[C_TCLR]) m_cnt = 0;
      else if (tick) m_cnt = (m_cnt + 1) % 32768;
      if (tick) m_tcnt = (m_tcnt + 1) % 16;
      if (cmdv[C_TDIS]) m_ten = 0; else if (cmdv[C_TEN]) m_ten = 1;
      if (cmdv[C_WDIS]) m_wen = 0; else if (cmdv[C_WEN]) m_wen = 1;
      if (cmdv[C_IDIS]) m_ien = 0; else if (cmdv[C_IEN]) m_ien = 1;
      if (cmdv[C_RWE]) m_sel = rsel;
      if (cmdv[C_TOFF]) m_tmode = 0;
      else if (cmdv[C_THI]) m_tmode = 2;
      else if (cmdv[C_TLO]) m_tmode = 1;
    end
  end

  // Compare with the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk(tb_wave == m_tb,    "R2/R3 tb_wave model", tb_wave, m_tb);
      chk(wdt_flag == m_flag, "R5/R6 wdt_flag model", wdt_flag, m_flag);
      chk(irq_n == m_irqn,    "R7 irq_n model", irq_n, m_irqn);
      chk(tone_p == m_tp,     "R9 tone_p model", tone_p, m_tp);
      chk(tone_n == m_tn,     "R9 tone_n model", tone_n, m_tn);
    end
  end

  task automatic issue(input logic [11:0] v, input logic [2:0] s);
    @(negedge clk);
    cmdv = v;
    rsel = s;
    @(negedge clk);
    cmdv = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_rises(input bit which, input int n, output int rises);
    bit prev, cur;
    rises = 0;
    @(negedge clk);
    prev = which ? tone_p : tb_wave;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur = which ? tone_p : tb_wave;
      if (cur && !prev) rises++;
      prev = cur;
    end
  endtask

  task automatic wait_flag(input int limit, output int waited);
    waited = 0;
    while (!wdt_flag && waited < limit) begin
      @(negedge clk);
      waited++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r, w;
    bit ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(tb_wave == 0, "R1 tb_wave", tb_wave, 0);
    chk(wdt_flag == 0, "R1 wdt_flag", wdt_flag, 0);
    chk(irq_n == 1, "R1 irq_n", irq_n, 1);
    chk(tone_p == 0 && tone_n == 0, "R1 tone", {tone_p, tone_n}, 0);
    idle(300);
    chk(tb_wave == 0, "R3 disabled timer", tb_wave, 0);

    // R2/R10: rate 7 then 6
    issue((12'd1 << C_RWE) | (12'd1 << C_TEN), 3'd7);
    count_rises(1'b0, 1024, r);
    chk(r == 4, "R2 rate7 rises in 1024", r, 4);
    issue(12'd1 << C_RWE, 3'd6);
    count_rises(1'b0, 1024, r);
    chk(r == 2, "R10 rate6 rises in 1024", r, 2);

    // R4: clear, including a clear that lands on a tick
    issue(12'd1 << C_TCLR, 3'd0);
    @(negedge clk);
    chk(tb_wave == 0, "R4 wave after clear", tb_wave, 0);
    idle(200);

    // R3: disable timer
    issue(12'd1 << C_TDIS, 3'd0);
    idle(2);
    ok = 1;
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (tb_wave) ok = 0; end
    chk(ok, "R3 wave held low", tb_wave, 0);

    // R7: interrupt follows wave
    issue((12'd1 << C_IEN) | (12'd1 << C_TEN) | (12'd1 << C_RWE), 3'd7);
    idle(400);

    // R5: watchdog timeout at rate 7 after four periods
    issue((12'd1 << C_TCLR) | (12'd1 << C_WEN) | (12'd1 << C_WCLR), 3'd0);
    wait_flag(1200, w);
    chk(w >= 1015 && w <= 1025, "R5 timeout delay", w, 1020);
    chk(irq_n == 0, "R7 irq on timeout", irq_n, 0);
    ok = 1;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!wdt_flag || irq_n) ok = 0; end
    chk(ok, "R6 flag sticky, R7 priority", wdt_flag, 1);
    issue(12'd1 << C_WCLR, 3'd0);
    chk(wdt_flag == 0, "R6 cleared by wdt clear", wdt_flag, 0);

    // R6: clear coinciding with timeout
    begin
      bit hit;
      hit = 0;
      for (int i = 0; i < 1500 && !hit; i++) begin
        @(negedge clk);
        if (m_wen && m_wcnt == 3 && (((m_cnt + 1) % (1 << (15 - m_sel))) == 0)) hit = 1;
      end
      cmdv = 12'd1 << C_WCLR;
      @(negedge clk);
      cmdv = '0;
      chk(hit, "R6 coincidence reached", hit, 1);
      chk(wdt_flag == 0, "R6 clear wins over timeout", wdt_flag, 0);
    end

    // R6: interrupt disable clears flag, R7 irq high after
    wait_flag(1200, w);
    chk(wdt_flag == 1, "R5 second timeout", wdt_flag, 1);
    issue(12'd1 << C_IDIS, 3'd0);
    chk(wdt_flag == 0, "R6 cleared by irq disable", wdt_flag, 0);
    @(negedge clk);
    chk(irq_n == 1, "R7 irq high after disable", irq_n, 1);

    // R8: watchdog disabled while timer keeps running; sparse ticks
    tick_mode = 1;
    issue((12'd1 << C_WDIS) | (12'd1 << C_WCLR), 3'd0);
    count_rises(1'b0, 1500, r);
    chk(r >= 1, "R8 timer independent of wdt", r, 2);
    chk(wdt_flag == 0, "R8 wdt disabled no timeout", wdt_flag, 0);
    tick_mode = 0;

    // R8: enable and disable together, disable wins
    issue(12'd1 << C_TDIS, 3'd0);
    issue((12'd1 << C_TEN) | (12'd1 << C_TDIS), 3'd0);
    ok = 1;
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (tb_wave) ok = 0; end
    chk(ok, "R8 disable wins", tb_wave, 0);

    // R9: tones
    issue(12'd1 << C_THI, 3'd0);
    count_rises(1'b1, 64, r);
    chk(r == 8, "R9 high tone rises", r, 8);
    chk(tone_n == !tone_p, "R9 complement", tone_n, !tone_p);
    issue((12'd1 << C_TLO) | (12'd1 << C_THI), 3'd0);
    count_rises(1'b1, 64, r);
    chk(r == 8, "R9 high beats low", r, 8);
    issue(12'd1 << C_TLO, 3'd0);
    count_rises(1'b1, 64, r);
    chk(r == 4, "R9 low tone rises", r, 4);
    issue((12'd1 << C_TOFF) | (12'd1 << C_THI), 3'd0);
    @(negedge clk);
    ok = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (tone_p || tone_n) ok = 0; end
    chk(ok, "R9 off wins, outputs low", {tone_p, tone_n}, 0);

    // R10: sparse ticks with rate change
    tick_mode = 1;
    issue((12'd1 << C_TEN) | (12'd1 << C_RWE) | (12'd1 << C_IEN), 3'd5);
    idle(800);
    issue(12'd1 << C_THI, 3'd0);
    idle(200);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule